// File: doc/BRIEF.md
# Majority-Clocked Triple Shift-Register Keystream Core

This core holds three binary linear-feedback shift registers, 19, 22 and 23 bits wide, and produces one keystream bit per step strobe. On each step, one control bit from the middle of each register takes part in a vote. A register advances only when its control bit agrees with the majority value. This means at least two of the three registers move on every step, so the generator never stalls.

A separate controller drives the core. It loads all three registers in parallel with a key-derived state. It then issues step strobes, optionally raising the one-bit injection input to fold a frame counter into the state, and collects the keystream bit after each step. The register contents are visible at the outputs so the controller or a test can observe them.

Top module: `triple_lfsr_core`

## Requirements
- R1: After reset all three registers are zero and the keystream output is 0.
- R2: When `load_i` is 1, the three registers take `load_a_i`, `load_b_i` and `load_c_i` at the next clock edge. This holds whatever `step_i` and `inject_i` are in that cycle.
- R3: When neither `load_i` nor `step_i` is 1, all three registers hold their values, and `inject_i` has no effect.
- R4: On a step, the control bits are bit 9 of register A, bit 11 of register B and bit 11 of register C. A register shifts only if its control bit equals the majority value of the three, so two or three registers shift on every step.
- R5: When register A (19 bits) shifts, it moves toward its MSB. The new bit 0 is the XOR of its old bits 18, 17, 16 and 13.
- R6: When register B (22 bits) shifts, it moves toward its MSB. The new bit 0 is the XOR of its old bits 21, 20, 16 and 12.
- R7: When register C (23 bits) shifts, it moves toward its MSB. The new bit 0 is the XOR of its old bits 22, 21, 18 and 17.
- R8: On a step with `inject_i` at 1, bit 0 of every register is inverted after the shift. This includes any register that did not shift.
- R9: `ks_bit_o` is the XOR of bit 18 of A, bit 21 of B and bit 22 of C in the current register state. It shows the post-step value in the same cycle as the new register contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, clears all registers |
| load_i | input | 1 | Parallel load of all three registers |
| step_i | input | 1 | Advance the generator by one step |
| inject_i | input | 1 | Invert bit 0 of every register on a step |
| load_a_i | input | 19 | Load value for register A |
| load_b_i | input | 22 | Load value for register B |
| load_c_i | input | 23 | Load value for register C |
| ks_bit_o | output | 1 | Keystream bit from the current state |
| reg_a_o | output | 19 | Register A contents |
| reg_b_o | output | 22 | Register B contents |
| reg_c_o | output | 23 | Register C contents |

## Verification
Every register result is due exactly one clock edge after the load or step that causes it. The keystream bit follows the registers combinationally, so it is due at the same edge. The bench drives inputs on the falling edge. It advances its reference model once per cycle and compares all four outputs at the next falling edge, which comes after exactly one rising edge. The directed cases cover each vote pattern, each feedback tap set, injection into a register that holds, and loads colliding with steps. A long random run with frequent reloads covers the mixed cases.

// File: rtl/lfsr3_pkg.sv
package lfsr3_pkg;
    localparam int unsigned NREG   = 3;
    localparam int unsigned A_W    = 19;
    localparam int unsigned B_W    = 22;
    localparam int unsigned C_W    = 23;
    localparam int unsigned A_CTRL = 9;
    localparam int unsigned B_CTRL = 11;
    localparam int unsigned C_CTRL = 11;
    // feedback tap masks: a set bit joins the XOR that enters bit 0
    localparam logic [A_W-1:0] A_FB = A_W'((1 << 18) | (1 << 17) | (1 << 16) | (1 << 13));
    localparam logic [B_W-1:0] B_FB = B_W'((1 << 21) | (1 << 20) | (1 << 16) | (1 << 12));
    localparam logic [C_W-1:0] C_FB = C_W'((1 << 22) | (1 << 21) | (1 << 18) | (1 << 17));
endpackage

// File: rtl/lfsr_vote.sv
module lfsr_vote #(
    parameter int unsigned N = 3
) (
    input  logic [N-1:0] tap_i,
    output logic [N-1:0] move_o
);
    localparam int unsigned CW = $clog2(N + 1);

    logic [CW-1:0] ones;
    logic          maj;

    always_comb begin
        ones = '0;
        for (int i = 0; i < N; i++) begin
            ones = ones + CW'(tap_i[i]);
        end
        maj = (ones > CW'(N / 2));
    end

    for (genvar g = 0; g < N; g++) begin : g_move
        assign move_o[g] = (tap_i[g] == maj);
    end
endmodule

// File: rtl/lfsr_step.sv
module lfsr_step #(
    parameter int unsigned W    = 19,
    parameter logic [W-1:0] FB  = '0,
    parameter int unsigned CTRL = 9
) (
    input  logic [W-1:0] cur_i,
    input  logic         move_i,
    input  logic         inj_i,
    output logic [W-1:0] nxt_o,
    output logic         ctrl_o,
    output logic         msb_o
);
    logic fb_bit;

    always_comb begin
        fb_bit = ^(cur_i & FB);
        if (move_i) begin
            nxt_o = {cur_i[W-2:0], fb_bit};
        end else begin
            nxt_o = cur_i;
        end
        nxt_o[0] = nxt_o[0] ^ inj_i;
    end

    assign ctrl_o = cur_i[CTRL];
    assign msb_o  = cur_i[W-1];
endmodule

// File: rtl/triple_lfsr_core.sv
module triple_lfsr_core
    import lfsr3_pkg::*;
#(
    parameter int unsigned AW  = A_W,
    parameter int unsigned BW  = B_W,
    parameter int unsigned CW  = C_W,
    parameter logic [AW-1:0] AFB = A_FB,
    parameter logic [BW-1:0] BFB = B_FB,
    parameter logic [CW-1:0] CFB = C_FB,
    parameter int unsigned ACT = A_CTRL,
    parameter int unsigned BCT = B_CTRL,
    parameter int unsigned CCT = C_CTRL
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load_i,
    input  logic          step_i,
    input  logic          inject_i,
    input  logic [AW-1:0] load_a_i,
    input  logic [BW-1:0] load_b_i,
    input  logic [CW-1:0] load_c_i,
    output logic          ks_bit_o,
    output logic [AW-1:0] reg_a_o,
    output logic [BW-1:0] reg_b_o,
    output logic [CW-1:0] reg_c_o
);
    typedef struct packed {
        logic [AW-1:0] a;
        logic [BW-1:0] b;
        logic [CW-1:0] c;
    } core_state_t;

    core_state_t state_d, state_q;

    logic [NREG-1:0] tap, move, msb;
    logic [AW-1:0]   nxt_a;
    logic [BW-1:0]   nxt_b;
    logic [CW-1:0]   nxt_c;

    lfsr_step #(.W(AW), .FB(AFB), .CTRL(ACT)) u_step_a (
        .cur_i(state_q.a), .move_i(move[0]), .inj_i(inject_i),
        .nxt_o(nxt_a), .ctrl_o(tap[0]), .msb_o(msb[0]));

    lfsr_step #(.W(BW), .FB(BFB), .CTRL(BCT)) u_step_b (
        .cur_i(state_q.b), .move_i(move[1]), .inj_i(inject_i),
        .nxt_o(nxt_b), .ctrl_o(tap[1]), .msb_o(msb[1]));

    lfsr_step #(.W(CW), .FB(CFB), .CTRL(CCT)) u_step_c (
        .cur_i(state_q.c), .move_i(move[2]), .inj_i(inject_i),
        .nxt_o(nxt_c), .ctrl_o(tap[2]), .msb_o(msb[2]));

    lfsr_vote #(.N(NREG)) u_vote (
        .tap_i(tap), .move_o(move));

    always_comb begin
        state_d = state_q;
        if (load_i) begin
            state_d.a = load_a_i;
            state_d.b = load_b_i;
            state_d.c = load_c_i;
        end else if (step_i) begin
            state_d.a = nxt_a;
            state_d.b = nxt_b;
            state_d.c = nxt_c;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign ks_bit_o = ^msb;
    assign reg_a_o  = state_q.a;
    assign reg_b_o  = state_q.b;
    assign reg_c_o  = state_q.c;

    // load wins over any step or injection
    assert_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        load_i |=> (state_q.a == $past(load_a_i)) && (state_q.b == $past(load_b_i))
                   && (state_q.c == $past(load_c_i)));

    assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !step_i) |=> $stable(state_q));

    assert_two_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i) |-> ($countones(move) >= 2));

    assert_shift_a_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && move[0]) |=> state_q.a[AW-1:1] == $past(state_q.a[AW-2:0]));

    assert_shift_b_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && move[1]) |=> state_q.b[BW-1:1] == $past(state_q.b[BW-2:0]));

    assert_shift_c_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && move[2]) |=> state_q.c[CW-1:1] == $past(state_q.c[CW-2:0]));

    // a held register only sees the injected bit 0
    assert_inject_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (step_i && !load_i && !move[2]) |=>
            state_q.c == ($past(state_q.c) ^ CW'($past(inject_i))));
endmodule

// File: tb/test_triple_lfsr_core.sv
module test_triple_lfsr_core;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic load_i = 1'b0, step_i = 1'b0, inject_i = 1'b0;
    logic [18:0] load_a_i = '0;
    logic [21:0] load_b_i = '0;
    logic [22:0] load_c_i = '0;
    logic ks_bit_o;
    logic [18:0] reg_a_o;
    logic [21:0] reg_b_o;
    logic [22:0] reg_c_o;

    int n_run = 0;
    int n_fail = 0;

    logic [18:0] ma;
    logic [21:0] mb;
    logic [22:0] mc;

    always #2.5 clk = ~clk;

    triple_lfsr_core i_triple_lfsr_core (
        .clk(clk), .rst_n(rst_n), .load_i(load_i), .step_i(step_i), .inject_i(inject_i),
        .load_a_i(load_a_i), .load_b_i(load_b_i), .load_c_i(load_c_i),
        .ks_bit_o(ks_bit_o), .reg_a_o(reg_a_o), .reg_b_o(reg_b_o), .reg_c_o(reg_c_o));

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    // reference model of one step, from the requirements
    task automatic model_step(input logic inj);
        logic ta, tb, tc, mj;
        logic [18:0] na;
        logic [21:0] nb;
        logic [22:0] nc;
        ta = ma[9]; tb = mb[11]; tc = mc[11];
        mj = (ta & tb) | (ta & tc) | (tb & tc);
        na = (ta == mj) ? {ma[17:0], ma[18] ^ ma[17] ^ ma[16] ^ ma[13]} : ma;
        nb = (tb == mj) ? {mb[20:0], mb[21] ^ mb[20] ^ mb[16] ^ mb[12]} : mb;
        nc = (tc == mj) ? {mc[21:0], mc[22] ^ mc[21] ^ mc[18] ^ mc[17]} : mc;
        na[0] ^= inj; nb[0] ^= inj; nc[0] ^= inj;
        ma = na; mb = nb; mc = nc;
    endtask

    task automatic cyc(input logic ld, input logic st, input logic inj,
                       input logic [18:0] a, input logic [21:0] b, input logic [22:0] c);
        load_i = ld; step_i = st; inject_i = inj;
        load_a_i = a; load_b_i = b; load_c_i = c;
        @(negedge clk);
        if (ld) begin
            ma = a; mb = b; mc = c;
        end else if (st) begin
            model_step(inj);
        end
        chk("R5 reg A", 32'(reg_a_o), 32'(ma));
        chk("R6 reg B", 32'(reg_b_o), 32'(mb));
        chk("R7 reg C", 32'(reg_c_o), 32'(mc));
        chk("R9 keystream", 32'(ks_bit_o), 32'(ma[18] ^ mb[21] ^ mc[22]));
    endtask

    initial begin
        #1000000;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd4711));
        ma = '0; mb = '0; mc = '0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 reg A", 32'(reg_a_o), 0);
        chk("R1 reg B", 32'(reg_b_o), 0);
        chk("R1 reg C", 32'(reg_c_o), 0);
        chk("R1 keystream", 32'(ks_bit_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        // all-zero state: every tap 0, all move, stays zero
        cyc(0, 1, 0, '0, '0, '0);
        chk("R4 zero stays zero", 32'(reg_a_o | reg_b_o | reg_c_o), 0);
        // R2 load beats step and inject
        cyc(1, 1, 1, 19'h5A5A5, 22'h2BCDEF, 23'h123456);
        chk("R2 load A", 32'(reg_a_o), 32'h5A5A5);
        chk("R2 load C", 32'(reg_c_o), 32'h123456);
        // R3 inject without step ignored
        cyc(0, 0, 1, '0, '0, '0);
        chk("R3 hold A", 32'(reg_a_o), 32'h5A5A5);
        chk("R3 hold B", 32'(reg_b_o), 32'h2BCDEF);
        // R4 taps 1,1,0: A and B move, C holds
        cyc(1, 0, 0, 19'(1 << 9), 22'(1 << 11), '0);
        cyc(0, 1, 0, '0, '0, '0);
        chk("R4 A moved", 32'(reg_a_o), 32'(1 << 10));
        chk("R4 B moved", 32'(reg_b_o), 32'(1 << 12));
        chk("R4 C held", 32'(reg_c_o), 0);
        // R8 taps 0,0,1 with inject: C holds yet bit 0 flips
        cyc(1, 0, 0, '0, '0, 23'(1 << 11));
        cyc(0, 1, 1, '0, '0, '0);
        chk("R8 A", 32'(reg_a_o), 1);
        chk("R8 B", 32'(reg_b_o), 1);
        chk("R8 C held+inject", 32'(reg_c_o), 32'((1 << 11) | 1));
        // feedback taps one at a time
        cyc(1, 0, 0, 19'(1 << 13), '0, '0);
        cyc(0, 1, 0, '0, '0, '0);
        chk("R5 tap13", 32'(reg_a_o), 32'((1 << 14) | 1));
        cyc(1, 0, 0, '0, 22'(1 << 12), '0);
        cyc(0, 1, 0, '0, '0, '0);
        chk("R6 tap12", 32'(reg_b_o), 32'((1 << 13) | 1));
        cyc(1, 0, 0, '0, '0, 23'(1 << 17));
        cyc(0, 1, 0, '0, '0, '0);
        chk("R7 tap17", 32'(reg_c_o), 32'((1 << 18) | 1));
        // R9 keystream right after load and after step
        cyc(1, 0, 0, 19'(1 << 18), '0, '0);
        chk("R9 ks after load", 32'(ks_bit_o), 1);
        cyc(0, 1, 0, '0, '0, '0);
        chk("R9 ks after step", 32'(ks_bit_o), 0);
        chk("R5 msb wraps", 32'(reg_a_o), 1);
        // random mix
        for (int i = 0; i < 4000; i++) begin
            int r;
            r = int'($urandom % 100);
            cyc(r < 6, r < 85, ($urandom % 3) == 0,
                19'($urandom), 22'($urandom), 23'($urandom));
        end
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule